// File: doc/BRIEF.md
# SPI EEPROM Instruction Engine

This block lets a host run serial EEPROM instructions through a small 8-bit register bus. The host first loads an address byte and a data byte. It then writes an instruction byte, and that single write starts one complete SPI frame. The block chooses the frame from the opcode, shifts it out, and keeps any byte returned by the memory in a read-only data-in register. While the frame runs, a busy flag is set in the status register. The host polls that flag before it reads the result or issues the next instruction.

A byte write to the memory is a host-driven sequence of single-frame instructions:
1. Enable writes.
2. Poll the memory status until its write-enable latch reads 1.
3. Issue the write.
4. Poll the memory status until its write-in-progress bit reads 0.
5. Disable writes.

Address bit 8 travels in bit 3 of the READ and WRITE opcodes, so the host folds it into the instruction byte. The block sends the instruction byte exactly as it was written.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, and every register reads 0x00.
- R2: Register offsets are fixed. The status register sits at 0x02. Data-in sits at 0x06 and is read-only. Data-out at 0x08, address at 0x0A and instruction at 0x0C all read back what was last written to them. Any other offset reads 0x00.
- R3: A write to offset 0x0C while the block is idle starts a frame. Status bit 2 reads 1 from the next clock until the frame has ended.
- R4: The SPI link runs in mode 0, most significant bit first. SCLK idles low, and MOSI changes only while SCLK is low. MISO is sampled on the SCLK rising edge. Each SCLK phase lasts SCLK_HALF system clocks.
- R5: Frame length depends on the opcode:
  - 0x06 (enable writes) and 0x04 (disable writes): 8 SCLK cycles.
  - 0x05 (read status): 16 SCLK cycles.
  - READ (0x03 or 0x0B) and WRITE (0x02 or 0x0A): 24 SCLK cycles.
  - Any other opcode: 8 SCLK cycles.
- R6: MOSI carries the opcode byte as written, with bit 3 holding address bit 8. For READ and WRITE, the address register byte follows. For WRITE, the data-out register byte comes third. The trailing byte of a read-status or READ frame is sent as zeros.
- R7: After a read-status or READ frame, data-in holds the last 8 bits sampled on MISO. Every other opcode leaves data-in unchanged.
- R8: Chip select stays low for the whole frame. Busy clears only after chip select has been high for at least SCLK_HALF clocks.
- R9: A write to offset 0x0C while busy starts no frame, and the instruction register keeps its previous value.
- R10: Run against a behavioural EEPROM, the enable / poll / write / poll / disable sequence stores a byte. A following READ returns that byte, in both the lower and the upper half of a 512-byte array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register offset for both reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the memory |
| spi_miso | input | 1 | SPI data from the memory |

## Verification
Every one of the 256 opcode values is issued with its own address and data bytes, so the frame length and the MOSI content are checked for the four length classes. This sweep separates the READ and WRITE encodings that carry address bit 8 from the unknown opcodes that sit next to them. Capturing and non-capturing opcodes are told apart by comparing data-in with the bits a bench monitor saw on MISO, or with its value before the frame. A mid-frame instruction write checks that the block ignores a new command while busy. A complete byte-write sequence against a behavioural EEPROM, at a low and a high address, shows that the status polling and the address-bit-8 folding work together.

// File: rtl/eeprom_eng_pkg.sv
package eeprom_eng_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 3 * BYTE_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  // opcodes; READ and WRITE also match with bit 3 (address bit 8) set
  localparam logic [BYTE_W-1:0] OPC_WEN_SET = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_WEN_CLR = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_STATUS  = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_RD      = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_WR      = 8'h02;
  localparam logic [BYTE_W-1:0] A8_MASK     = 8'hF7;

  // register offsets seen by the host
  localparam logic [BYTE_W-1:0] OFS_STAT  = 8'h02;
  localparam logic [BYTE_W-1:0] OFS_RXB   = 8'h06;
  localparam logic [BYTE_W-1:0] OFS_TXB   = 8'h08;
  localparam logic [BYTE_W-1:0] OFS_ADR   = 8'h0A;
  localparam logic [BYTE_W-1:0] OFS_INSN  = 8'h0C;
  localparam int                STAT_BUSY = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_GAP} phase_t;

  function automatic logic op_is_rd(input logic [BYTE_W-1:0] op);
    return (op & A8_MASK) == OPC_RD;
  endfunction

  function automatic logic op_is_wr(input logic [BYTE_W-1:0] op);
    return (op & A8_MASK) == OPC_WR;
  endfunction

  function automatic logic op_captures(input logic [BYTE_W-1:0] op);
    return op_is_rd(op) || (op == OPC_STATUS);
  endfunction

  function automatic logic [LEN_W-1:0] op_frame_len(input logic [BYTE_W-1:0] op);
    if (op_is_rd(op) || op_is_wr(op)) return LEN_W'(FRAME_W);
    if (op == OPC_STATUS)             return LEN_W'(2 * BYTE_W);
    return LEN_W'(BYTE_W);
  endfunction

  // frame left-aligned: opcode leaves first
  function automatic logic [FRAME_W-1:0] op_frame(input logic [BYTE_W-1:0] op,
                                                  input logic [BYTE_W-1:0] adr,
                                                  input logic [BYTE_W-1:0] txb);
    logic [BYTE_W-1:0] mid, tail;
    mid  = (op_is_rd(op) || op_is_wr(op)) ? adr : '0;
    tail = op_is_wr(op) ? txb : '0;
    return {op, mid, tail};
  endfunction
endpackage

// File: rtl/eeprom_eng_regs.sv
module eeprom_eng_regs
  import eeprom_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rxb,
  output logic              start,
  output logic [BYTE_W-1:0] insn_q,
  output logic [BYTE_W-1:0] adr_q,
  output logic [BYTE_W-1:0] txb_q
);
  logic insn_wr, insn_dropped;

  assign insn_wr      = bus_wr && (bus_addr == OFS_INSN);
  assign start        = insn_wr && !busy;
  assign insn_dropped = insn_wr && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q <= '0;
      adr_q  <= '0;
      txb_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_TXB) txb_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_ADR) adr_q <= bus_wdata;
      if (start)                         insn_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STAT: bus_rdata[STAT_BUSY] = busy;
      OFS_RXB:  bus_rdata = rxb;
      OFS_TXB:  bus_rdata = txb_q;
      OFS_ADR:  bus_rdata = adr_q;
      OFS_INSN: bus_rdata = insn_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R9
  drop_insn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_dropped |=> $stable(insn_q));
endmodule

// File: rtl/eeprom_eng_seq.sv
module eeprom_eng_seq
  import eeprom_eng_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] insn,
  input  logic [BYTE_W-1:0] adr,
  input  logic [BYTE_W-1:0] txb,
  output logic              busy,
  output logic [BYTE_W-1:0] rxb,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int            CW       = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SCLK_HALF - 1);

  phase_t             ph;
  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   nbits, bitcnt;
  logic               cap;
  logic [BYTE_W-1:0]  rx;

  // named internal events
  logic half_end, sclk_rise, last_bit, frame_done;
  assign half_end   = (ph != PH_IDLE) && (cnt == CNT_LAST);
  assign sclk_rise  = (ph == PH_LOW) && half_end;
  assign last_bit   = (bitcnt == nbits - LEN_W'(1));
  assign frame_done = (ph == PH_GAP) && half_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      nbits  <= '0;
      bitcnt <= '0;
      cap    <= 1'b0;
      rx     <= '0;
      rxb    <= '0;
    end else begin
      if (ph == PH_IDLE || half_end) cnt <= '0;
      else                           cnt <= cnt + CW'(1);
      case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_LOW;
          shreg  <= op_frame(insn, adr, txb);
          nbits  <= op_frame_len(insn);
          bitcnt <= '0;
          cap    <= op_captures(insn);
        end
        PH_LOW: if (half_end) begin
          ph <= PH_HIGH;
          rx <= {rx[BYTE_W-2:0], miso};
        end
        PH_HIGH: if (half_end) begin
          shreg  <= {shreg[FRAME_W-2:0], 1'b0};
          bitcnt <= bitcnt + LEN_W'(1);
          ph     <= last_bit ? PH_GAP : PH_LOW;
        end
        PH_GAP: if (half_end) begin
          ph <= PH_IDLE;
          if (cap) rxb <= rx;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy = (ph != PH_IDLE);
  assign cs_n = !((ph == PH_LOW) || (ph == PH_HIGH));
  assign sclk = (ph == PH_HIGH);
  assign mosi = !cs_n && shreg[FRAME_W-1];

  // checker counter: SCLK rises seen in the current frame
  logic [LEN_W-1:0] rise_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rise_cnt <= '0;
    else if (start)     rise_cnt <= '0;
    else if (sclk_rise) rise_cnt <= rise_cnt + LEN_W'(1);
  end

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == nbits));
  // R7
  rxb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cap) |=> $stable(rxb));
  // R8
  busy_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cs_n) && cs_n));
endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
  import eeprom_eng_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic              start, busy;
  logic [BYTE_W-1:0] insn_q, adr_q, txb_q, rxb;

  eeprom_eng_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .rxb       (rxb),
    .start     (start),
    .insn_q    (insn_q),
    .adr_q     (adr_q),
    .txb_q     (txb_q)
  );

  eeprom_eng_seq #(.SCLK_HALF(SCLK_HALF)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .insn  (bus_wdata),
    .adr   (adr_q),
    .txb   (txb_q),
    .busy  (busy),
    .rxb   (rxb),
    .cs_n  (spi_cs_n),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .miso  (spi_miso)
  );

  // R1
  cs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
endmodule

// File: tb/tb_eeprom_cmd_engine.sv
module tb_eeprom_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 2;

  logic       clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic       cs_n, sclk, mosi, miso = 0;
  int         tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_cmd_engine #(.SCLK_HALF(SCLK_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(cs_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso));

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---------------- bus monitor of the SPI link ----------------
  int          mon_bits = 0, mon_frames = 0;
  logic [31:0] mon_word = 0;
  logic [7:0]  mon_miso = 0;
  time         t_prev = 0, t_last = 0, t_csr = 0;
  always @(negedge cs_n) begin mon_bits = 0; mon_word = 0; mon_miso = 0; end
  always @(posedge sclk) if (!cs_n) begin
    mon_bits++;
    mon_word = {mon_word[30:0], mosi};
    mon_miso = {mon_miso[6:0], miso};
    t_prev = t_last; t_last = $time;
  end
  always @(posedge cs_n) begin mon_frames++; t_csr = $time; end

  // ---------------- behavioural EEPROM ----------------
  logic [7:0] mem [0:511];
  bit         wel = 0, wip = 0;
  int         wip_cnt = 0, mb = 0;
  logic [7:0] mop = 0, madr = 0, mdat = 0, mout = 0;
  initial for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h5A;
  always @(negedge cs_n) begin mb = 0; mop = 0; madr = 0; mdat = 0; mout = 0; end
  always @(posedge sclk) if (!cs_n) begin
    mb++;
    if (mb <= 8)       mop  = {mop[6:0], mosi};
    else if (mb <= 16) madr = {madr[6:0], mosi};
    else if (mb <= 24) mdat = {mdat[6:0], mosi};
    if (mb == 8 && mop == 8'h05) mout = {6'b0, wel, wip};
    if (mb == 16 && (mop & 8'hF7) == 8'h03) mout = mem[{mop[3], madr}];
  end
  always @(negedge sclk) if (!cs_n) begin miso = mout[7]; mout = {mout[6:0], 1'b0}; end
  always @(posedge cs_n) begin
    if (mb == 8 && mop == 8'h06) wel = 1;
    if (mb == 8 && mop == 8'h04) wel = 0;
    if (mb == 24 && (mop & 8'hF7) == 8'h02 && wel) begin
      mem[{mop[3], madr}] = mdat; wip = 1; wip_cnt = 3;
    end
    if (mb == 16 && mop == 8'h05 && wip) begin
      wip_cnt--;
      if (wip_cnt == 0) begin wip = 0; wel = 0; end
    end
  end

  // ---------------- expected values from the requirements ----------------
  function automatic int exp_len(input logic [7:0] op);
    if (op == 8'h02 || op == 8'h0A || op == 8'h03 || op == 8'h0B) return 24;
    if (op == 8'h05) return 16;
    return 8;
  endfunction
  function automatic logic [31:0] exp_word(input logic [7:0] op, a, d);
    case (op)
      8'h02, 8'h0A: return {8'h00, op, a, d};
      8'h03, 8'h0B: return {8'h00, op, a, 8'h00};
      8'h05:        return {16'h0, op, 8'h00};
      default:      return {24'h0, op};
    endcase
  endfunction

  // ---------------- host tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask
  time t_idle;
  task automatic wait_idle();
    logic [7:0] s; int n = 0;
    do begin @(negedge clk); rd(8'h02, s); n++; end while (s[2] && n < 2000);
    t_idle = $time;
  endtask
  task automatic send(input logic [7:0] op);
    wr(8'h0C, op); wait_idle();
  endtask

  task automatic eeprom_byte_write(input logic [8:0] a, input logic [7:0] d);
    logic [7:0] s; int n;
    wr(8'h0A, a[7:0]); wr(8'h08, d);
    send(8'h06);
    n = 0;
    do begin send(8'h05); rd(8'h06, s); n++; end while (!s[1] && n < 20);
    chk(s[1], "R10 write-enable latch seen", s, 8'h02);
    send(8'h02 | {4'b0, a[8], 3'b0});
    n = 0;
    do begin send(8'h05); rd(8'h06, s); n++; end while (s[0] && n < 20);
    chk(!s[0], "R10 write finished", s, 0);
    send(8'h04);
    chk(mem[a] == d, "R10 model memory", mem[a], d);
    send(8'h03 | {4'b0, a[8], 3'b0});
    rd(8'h06, s);
    chk(s == d, "R10 read back", s, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, a8, d8, din0, din1;
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1, "R1 cs_n at reset", cs_n, 1);
    chk(sclk === 1'b0 && mosi === 1'b0, "R1 sclk/mosi at reset", {sclk, mosi}, 0);
    foreach (v[i]) ;
    rd(8'h02, v); chk(v == 0, "R1 status at reset", v, 0);
    rd(8'h06, v); chk(v == 0, "R1 data-in at reset", v, 0);
    rd(8'h0C, v); chk(v == 0, "R1 instruction at reset", v, 0);
    // R2 register map
    wr(8'h08, 8'hA5); wr(8'h0A, 8'h5A); wr(8'h06, 8'hFF);
    rd(8'h08, v); chk(v == 8'hA5, "R2 data-out readback", v, 8'hA5);
    rd(8'h0A, v); chk(v == 8'h5A, "R2 address readback", v, 8'h5A);
    rd(8'h06, v); chk(v == 8'h00, "R2 data-in read-only", v, 0);
    rd(8'h10, v); chk(v == 8'h00, "R2 unmapped offset", v, 0);
    // R3 busy and R8 chip select timing
    wr(8'h0C, 8'h06);
    rd(8'h02, v); chk(v == 8'h04, "R3 busy after start", v, 8'h04);
    chk(cs_n == 1'b0, "R8 cs_n low in frame", cs_n, 0);
    wait_idle();
    chk((t_idle - t_csr) >= SCLK_HALF * CLK_PERIOD, "R8 busy clears after cs_n high",
        t_idle - t_csr, SCLK_HALF * CLK_PERIOD);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R4 idle levels", {cs_n, sclk}, 2'b10);
    rd(8'h0C, v); chk(v == 8'h06, "R2 instruction readback", v, 8'h06);
    // opcode sweep: R5 lengths, R6 content, R7 capture
    for (int op = 0; op < 256; op++) begin
      a8 = 8'(op) ^ 8'h3C; d8 = ~8'(op) + 8'h11;
      wr(8'h0A, a8); wr(8'h08, d8);
      rd(8'h06, din0);
      send(8'(op));
      chk(mon_bits == exp_len(8'(op)), "R5 frame length", mon_bits, exp_len(8'(op)));
      chk(mon_word == exp_word(8'(op), a8, d8), "R6 MOSI content", mon_word,
          exp_word(8'(op), a8, d8));
      rd(8'h06, din1);
      if (op == 8'h05 || op == 8'h03 || op == 8'h0B)
        chk(din1 == mon_miso, "R7 captured byte", din1, mon_miso);
      else
        chk(din1 == din0, "R7 data-in unchanged", din1, din0);
      if (op == 8'h0B)
        chk((t_last - t_prev) == 2 * SCLK_HALF * CLK_PERIOD, "R4 SCLK period",
            t_last - t_prev, 2 * SCLK_HALF * CLK_PERIOD);
    end
    // R9 instruction write while busy is dropped
    wr(8'h0A, 8'h21);
    f0 = mon_frames;
    wr(8'h0C, 8'h03);
    repeat (10) @(negedge clk);
    wr(8'h0C, 8'h06);
    rd(8'h0C, v); chk(v == 8'h03, "R9 instruction kept", v, 8'h03);
    wait_idle();
    repeat (60) @(negedge clk);
    chk(mon_frames == f0 + 1, "R9 no extra frame", mon_frames - f0, 1);
    chk(mon_bits == 24, "R9 original frame length", mon_bits, 24);
    // R10 full write sequence, low and high half
    eeprom_byte_write(9'h005, 8'hC3);
    eeprom_byte_write(9'h1A3, 8'h7E);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule